// File: doc/BRIEF.md
# Flash Sector-Protection Command Sequencer

This block sits on the write side of a NOR-style flash device and turns multi-cycle, address-qualified command sequences into single-cycle operation strobes. The `we_n` strobe is sampled on the system clock. Each rising edge of `we_n` captures one bus write, which then moves a sequence state machine forward. Every sequence opens with two unlock writes and a command write. Some commands then take an arm write and a verify write. Between those two writes a minimum wait, counted in clock cycles, must pass. That wait stands in for the protection-bit program and erase times. A password of four byte portions is loaded one portion per full sequence, and consecutive portions must also be a minimum number of cycles apart.

Results come back on a readback byte. Bit 0 carries the verify outcome, bit 1 carries the protection-lock status, and 8'hFF is returned for a refused password command. When a protection-bit program or erase passes verification, the block emits a strobe, together with the sector taken from the upper address bits at the arm write. Array storage and the actual cell work are outside this block.

States: `ST_READ` (array read, waiting for the first unlock write), `ST_UNLOCK2`, `ST_COMMAND`, `ST_PROG_ARM`, `ST_PROG_WAIT`, `ST_ERASE_ARM`, `ST_ERASE_WAIT`, `ST_LOCK_ARM`, `ST_PW_DATA` and `ST_PWLOCK_ARM`.

Transitions:
- `ST_READ` goes to `ST_UNLOCK2` on 555h/AAh.
- `ST_UNLOCK2` goes to `ST_COMMAND` on 2AAh/55h.
- `ST_COMMAND` at address 555h branches on the command byte:
  - 60h goes to `ST_PROG_ARM`.
  - 80h goes to `ST_ERASE_ARM`.
  - 78h goes to `ST_LOCK_ARM`.
  - 28h goes to `ST_PWLOCK_ARM`.
  - 38h goes to `ST_PW_DATA`, or back to `ST_READ` with FFh when the password lock is set.
  - 50h goes back to `ST_READ` with a status readback.
- `ST_PROG_ARM` goes to `ST_PROG_WAIT` on 68h.
- `ST_ERASE_ARM` goes to `ST_ERASE_WAIT` on 30h.
- Every other state, and every mismatch, returns to `ST_READ`.
- A write of F0h returns to `ST_READ` from any state.

Top module: `flash_prot_decoder`

## Requirements
- R1: A bus write takes effect only on a rising edge of `we_n`. Holding `we_n` low over many clocks changes no output until `we_n` rises.
- R2: Unlock and command writes compare only address bits [11:0] against 555h and 2AAh. Bits above bit 11 never affect sequence matching.
- R3: An address or data mismatch in an unlock, command or arm write returns the block to `ST_READ` (`in_read` = 1) with no strobe and no password change. This includes an unknown command byte.
- R4: The program sequence is unlock, 555h/60h, sector address/68h, then any address/48h. If the 48h write comes at least PROG_GAP cycles after the 68h write and the lock is clear, `prog_stb` pulses for one cycle, `op_sector` holds addr[ADDR_W-1:12] of the 68h write, and `rd_byte` becomes 01h.
- R5: The erase sequence is unlock, 555h/80h, any/30h, then any/48h. If the 48h write comes at least ERASE_GAP cycles after the 30h write and the lock is clear, `erase_stb` pulses and `rd_byte` becomes 00h.
- R6: A 48h verify write that arrives before its minimum gap aborts the sequence. No strobe is issued and the block returns to `ST_READ`.
- R7: Command 50h sets `rd_byte` to 02h when the protection lock is set and to 00h when it is clear.
- R8: Unlock, 555h/78h, any/01h sets the protection lock until reset. With the lock set, a verify that passes the gap gives no strobe, and `rd_byte` reads 00h after a program and 01h after an erase.
- R9: Password sequence: unlock, 555h/38h, then a write whose address bits [11:2] are 0. Address bits [1:0] select portion p, and the data byte lands in `password[8p+7:8p]`. `pw_stb` pulses and no other portion changes.
- R10: A password portion write is accepted only if it comes at least PW_GAP cycles after the last accepted portion write. Otherwise it is dropped and the block returns to `ST_READ`.
- R11: Unlock, 555h/28h, any/01h sets the password lock until reset. After that, command 38h sets `rd_byte` to FFh and ends the sequence, leaving the password unchanged.
- R12: A write with data F0h returns the block to `ST_READ` from any state, and the write takes no other effect.
- R13: After reset, `in_read` = 1, `rd_byte` = 00h, `password` = 0, `op_sector` = 0, all strobes are 0, and both locks are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Active-low write enable, synchronous to `clk` |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus data, DQ7..DQ0 |
| in_read | output | 1 | Sequencer is in array-read mode |
| rd_byte | output | 8 | Status readback byte |
| prog_stb | output | 1 | One-cycle protection-bit program strobe |
| erase_stb | output | 1 | One-cycle protection-bit erase strobe |
| pw_stb | output | 1 | One-cycle password portion write strobe |
| op_sector | output | ADDR_W-12 | Sector of the last armed program |
| password | output | 8<<PW_IDX_W | Stored password portions |

## Verification
Two events can fall in one cycle: a verify or portion write, and the expiry of the minimum-gap counter it is measured against. The bench sweeps the idle time before each 48h verify write, and before each password portion write, across a window that straddles the threshold. The rise-to-rise spacing is two clocks plus the inserted idle, so the bench computes the spacing arithmetically and expects acceptance exactly when it reaches the parameter. A second coincidence, F0h arriving while a gap is still running, is provoked mid-sequence and judged by the absence of any later strobe.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLOCK2,
        ST_COMMAND,
        ST_PROG_ARM,
        ST_PROG_WAIT,
        ST_ERASE_ARM,
        ST_ERASE_WAIT,
        ST_LOCK_ARM,
        ST_PW_DATA,
        ST_PWLOCK_ARM
    } seq_state_t;

    localparam logic [11:0] UNLOCK_A1 = 12'h555;
    localparam logic [11:0] UNLOCK_A2 = 12'h2AA;

    localparam logic [7:0] UNLOCK_D1 = 8'hAA;
    localparam logic [7:0] UNLOCK_D2 = 8'h55;
    localparam logic [7:0] OP_PROG   = 8'h60;
    localparam logic [7:0] OP_ERASE  = 8'h80;
    localparam logic [7:0] OP_STATUS = 8'h50;
    localparam logic [7:0] OP_LOCK   = 8'h78;
    localparam logic [7:0] OP_PW     = 8'h38;
    localparam logic [7:0] OP_PWLOCK = 8'h28;
    localparam logic [7:0] OP_RESET  = 8'hF0;
    localparam logic [7:0] ARM_PROG  = 8'h68;
    localparam logic [7:0] ARM_ERASE = 8'h30;
    localparam logic [7:0] VERIFY    = 8'h48;
    localparam logic [7:0] SET_BIT   = 8'h01;

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              cap_vld,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [7:0]        cap_data
);

    logic we_q;
    logic we_rise;

    assign we_rise = we_n & ~we_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            cap_vld  <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            we_q    <= we_n;
            cap_vld <= we_rise;
            if (we_rise) begin
                cap_addr <= addr;
                cap_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
    parameter int THR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic gap_ok
);

    localparam int LIM = (THR > 1) ? THR - 1 : 0;
    localparam int CW  = (LIM > 0) ? $clog2(LIM + 1) : 1;
    localparam logic [CW-1:0] LIM_V = CW'(LIM);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LIM_V;
        end else if (start) begin
            cnt <= '0;
        end else if (cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign gap_ok = (cnt == LIM_V);

endmodule

// File: rtl/flash_prot_decoder.sv
module flash_prot_decoder
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PW_IDX_W  = 2,
    parameter int PROG_GAP  = 10000,
    parameter int ERASE_GAP = 120000,
    parameter int PW_GAP    = 200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [7:0]                wdata,
    output logic                      in_read,
    output logic [7:0]                rd_byte,
    output logic                      prog_stb,
    output logic                      erase_stb,
    output logic                      pw_stb,
    output logic [ADDR_W-13:0]        op_sector,
    output logic [(8<<PW_IDX_W)-1:0]  password
);

    localparam int PORTIONS = 1 << PW_IDX_W;

    logic              cap_vld;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;
    logic [11:0]       a_lo;

    seq_state_t state, nxt;

    logic go_status, go_ff, arm_prog, arm_erase, ver_prog, ver_erase;
    logic set_lock, set_pwlock, pw_write;
    logic prog_ok, erase_ok, pw_ok;
    logic ppb_lock, pw_lock;
    logic [PW_IDX_W-1:0] pw_sel;

    flash_wr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_n     (we_n),
        .addr     (addr),
        .wdata    (wdata),
        .cap_vld  (cap_vld),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    flash_gap_timer #(.THR(PROG_GAP)) u_prog_gap (
        .clk(clk), .rst_n(rst_n), .start(arm_prog), .gap_ok(prog_ok)
    );

    flash_gap_timer #(.THR(ERASE_GAP)) u_erase_gap (
        .clk(clk), .rst_n(rst_n), .start(arm_erase), .gap_ok(erase_ok)
    );

    flash_gap_timer #(.THR(PW_GAP)) u_pw_gap (
        .clk(clk), .rst_n(rst_n), .start(pw_write), .gap_ok(pw_ok)
    );

    assign a_lo   = cap_addr[11:0];
    assign pw_sel = cap_addr[PW_IDX_W-1:0];

    // next state and per-write actions
    always_comb begin
        nxt        = state;
        go_status  = 1'b0;
        go_ff      = 1'b0;
        arm_prog   = 1'b0;
        arm_erase  = 1'b0;
        ver_prog   = 1'b0;
        ver_erase  = 1'b0;
        set_lock   = 1'b0;
        set_pwlock = 1'b0;
        pw_write   = 1'b0;
        if (cap_vld) begin
            if (cap_data == OP_RESET) begin
                nxt = ST_READ;
            end else begin
                unique case (state)
                    ST_READ: begin
                        if (a_lo == UNLOCK_A1 && cap_data == UNLOCK_D1)
                            nxt = ST_UNLOCK2;
                    end
                    ST_UNLOCK2: begin
                        if (a_lo == UNLOCK_A2 && cap_data == UNLOCK_D2)
                            nxt = ST_COMMAND;
                        else
                            nxt = ST_READ;
                    end
                    ST_COMMAND: begin
                        nxt = ST_READ;
                        if (a_lo == UNLOCK_A1) begin
                            case (cap_data)
                                OP_PROG:   nxt = ST_PROG_ARM;
                                OP_ERASE:  nxt = ST_ERASE_ARM;
                                OP_LOCK:   nxt = ST_LOCK_ARM;
                                OP_PWLOCK: nxt = ST_PWLOCK_ARM;
                                OP_STATUS: go_status = 1'b1;
                                OP_PW: begin
                                    if (pw_lock) go_ff = 1'b1;
                                    else         nxt   = ST_PW_DATA;
                                end
                                default:   nxt = ST_READ;
                            endcase
                        end
                    end
                    ST_PROG_ARM: begin
                        nxt = ST_READ;
                        if (cap_data == ARM_PROG) begin
                            nxt      = ST_PROG_WAIT;
                            arm_prog = 1'b1;
                        end
                    end
                    ST_PROG_WAIT: begin
                        nxt      = ST_READ;
                        ver_prog = (cap_data == VERIFY) && prog_ok;
                    end
                    ST_ERASE_ARM: begin
                        nxt = ST_READ;
                        if (cap_data == ARM_ERASE) begin
                            nxt       = ST_ERASE_WAIT;
                            arm_erase = 1'b1;
                        end
                    end
                    ST_ERASE_WAIT: begin
                        nxt       = ST_READ;
                        ver_erase = (cap_data == VERIFY) && erase_ok;
                    end
                    ST_LOCK_ARM: begin
                        nxt      = ST_READ;
                        set_lock = (cap_data == SET_BIT);
                    end
                    ST_PW_DATA: begin
                        nxt      = ST_READ;
                        pw_write = (a_lo[11:PW_IDX_W] == '0) && pw_ok;
                    end
                    ST_PWLOCK_ARM: begin
                        nxt        = ST_READ;
                        set_pwlock = (cap_data == SET_BIT);
                    end
                    default: nxt = ST_READ;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    // registered outputs and sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte   <= 8'h00;
            prog_stb  <= 1'b0;
            erase_stb <= 1'b0;
            pw_stb    <= 1'b0;
            ppb_lock  <= 1'b0;
            pw_lock   <= 1'b0;
            op_sector <= '0;
        end else begin
            prog_stb  <= ver_prog  & ~ppb_lock;
            erase_stb <= ver_erase & ~ppb_lock;
            pw_stb    <= pw_write;
            ppb_lock  <= ppb_lock | set_lock;
            pw_lock   <= pw_lock  | set_pwlock;
            if (arm_prog)
                op_sector <= cap_addr[ADDR_W-1:12];
            if (go_status)
                rd_byte <= {6'b0, ppb_lock, 1'b0};
            else if (go_ff)
                rd_byte <= 8'hFF;
            else if (ver_prog)
                rd_byte <= ppb_lock ? 8'h00 : 8'h01;
            else if (ver_erase)
                rd_byte <= ppb_lock ? 8'h01 : 8'h00;
        end
    end

    genvar g;
    generate
        for (g = 0; g < PORTIONS; g++) begin : g_pw
            logic [7:0] pw_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pw_q <= 8'h00;
                else if (pw_write && pw_sel == PW_IDX_W'(g))
                    pw_q <= cap_data;
            end
            assign password[8*g +: 8] = pw_q;
        end
    endgenerate

    assign in_read = (state == ST_READ);

endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk #(
    parameter int PW_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_read,
    input logic [7:0]      rd_byte,
    input logic            prog_stb,
    input logic            erase_stb,
    input logic            pw_stb,
    input logic [PW_W-1:0] password,
    input logic            ppb_lock,
    input logic            pw_lock
);

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, erase_stb, pw_stb}));

    assert_prog_ends_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |-> in_read);

    assert_erase_ends_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> in_read);

    assert_lock_blocks_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb || erase_stb) |-> !ppb_lock);

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ppb_lock));

    assert_pw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pw_stb |-> $stable(password));

    assert_pw_ends_in_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pw_stb |-> in_read);

    assert_pwlock_blocks_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pw_stb |-> !$past(pw_lock));

    assert_ff_needs_pwlock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte == 8'hFF) |-> pw_lock);

endmodule

bind flash_prot_decoder flash_prot_chk #(.PW_W(8 << PW_IDX_W)) u_flash_prot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_read   (in_read),
    .rd_byte   (rd_byte),
    .prog_stb  (prog_stb),
    .erase_stb (erase_stb),
    .pw_stb    (pw_stb),
    .password  (password),
    .ppb_lock  (ppb_lock),
    .pw_lock   (pw_lock)
);

// File: tb/test_flash_prot_decoder.sv
module test_flash_prot_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int PROG_GAP   = 12;
    localparam int ERASE_GAP  = 20;
    localparam int PW_GAP     = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              in_read, prog_stb, erase_stb, pw_stb;
    logic [7:0]        rd_byte;
    logic [3:0]        op_sector;
    logic [31:0]       password;

    int n_tests = 0;
    int n_fail  = 0;
    int n_prog  = 0;
    int n_erase = 0;
    int n_pw    = 0;
    bit done    = 1'b0;

    flash_prot_decoder #(
        .ADDR_W(ADDR_W), .PW_IDX_W(2),
        .PROG_GAP(PROG_GAP), .ERASE_GAP(ERASE_GAP), .PW_GAP(PW_GAP)
    ) i_flash_prot_decoder (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .in_read(in_read), .rd_byte(rd_byte), .prog_stb(prog_stb),
        .erase_stb(erase_stb), .pw_stb(pw_stb), .op_sector(op_sector),
        .password(password)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst_n && prog_stb)  n_prog++;
        if (rst_n && erase_stb) n_erase++;
        if (rst_n && pw_stb)    n_pw++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input int idle);
        repeat (idle) @(negedge clk);
        addr  = a;
        wdata = d;
        we_n  = 1'b0;
        @(negedge clk);
        we_n  = 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op, input int pre);
        wr(16'h0555, 8'hAA, pre);
        wr(16'h02AA, 8'h55, 0);
        wr(16'h0555, op, 0);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        report();
    end

    initial begin
        logic [31:0] exp_pw;
        int exp_prog;
        int exp_erase;
        exp_pw    = '0;
        exp_prog  = 0;
        exp_erase = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 in_read", {31'b0, in_read}, 32'd1);
        check("R13 rd_byte", {24'b0, rd_byte}, 32'h00);
        check("R13 password", password, 32'h0);
        check("R13 strobes", {29'b0, prog_stb, erase_stb, pw_stb}, 32'h0);
        check("R13 op_sector", {28'b0, op_sector}, 32'h0);

        // R1 write is taken only at the rising edge of we_n
        cmd(8'h38, 2);
        addr = 16'h0002; wdata = 8'h5E; we_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R1 held-low no effect", password, exp_pw);
        we_n = 1'b1;
        settle();
        exp_pw[23:16] = 8'h5E;
        check("R1 rising edge writes", password, exp_pw);

        // R2 address bits above 11 ignored by unlock matching
        wr(16'hF555, 8'hAA, 20);
        wr(16'h72AA, 8'h55, 0);
        wr(16'h3555, 8'h38, 0);
        wr(16'hA001, 8'h5A, 0);
        settle();
        exp_pw[15:8] = 8'h5A;
        check("R2 upper address ignored", password, exp_pw);

        // R9 each portion lands in its own byte
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d;
            d = 8'hA0 + 8'(i * 8'h13);
            cmd(8'h38, 20);
            wr(16'(i), d, 0);
            settle();
            exp_pw[8*i +: 8] = d;
            check("R9 portion select", password, exp_pw);
            check("R9 in_read", {31'b0, in_read}, 32'd1);
        end

        // R10 gap sweep between portions: spacing = 8 + idle
        for (int idle = 3; idle <= 8; idle++) begin
            logic [7:0] base_d, trial_d;
            int p;
            base_d  = 8'hC0 + 8'(idle);
            trial_d = 8'h40 + 8'(idle);
            p = idle % 3;
            cmd(8'h38, 20);
            wr(16'h0003, base_d, 0);
            exp_pw[31:24] = base_d;
            cmd(8'h38, 0);
            wr(16'(p), trial_d, idle);
            settle();
            if (8 + idle >= PW_GAP) exp_pw[8*p +: 8] = trial_d;
            check("R10 portion gap", password, exp_pw);
            check("R10 in_read", {31'b0, in_read}, 32'd1);
        end

        // R3 mismatches abort with no password change
        wr(16'h0555, 8'hAA, 20); wr(16'h02AA, 8'h56, 0);
        wr(16'h0555, 8'h38, 0);  wr(16'h0000, 8'h77, 0);
        settle();
        check("R3 bad unlock data", password, exp_pw);
        check("R3 bad unlock read", {31'b0, in_read}, 32'd1);
        cmd(8'h99, 20); wr(16'h0002, 8'h88, 0);
        settle();
        check("R3 unknown command", password, exp_pw);
        wr(16'h0555, 8'hAA, 20); wr(16'h02AA, 8'h55, 0);
        wr(16'h0554, 8'h38, 0);  wr(16'h0000, 8'h66, 0);
        settle();
        check("R3 bad command address", password, exp_pw);
        check("R3 back in read", {31'b0, in_read}, 32'd1);
        cmd(8'h38, 20); wr(16'h0010, 8'h67, 0);
        settle();
        check("R3 portion address above 1:0", password, exp_pw);

        // R12 F0 aborts from any state
        cmd(8'h38, 20); wr(16'h0000, 8'hF0, 0);
        settle();
        check("R12 F0 not stored", password, exp_pw);
        check("R12 F0 read mode", {31'b0, in_read}, 32'd1);
        cmd(8'h60, 2); wr(16'h5000, 8'h68, 0); wr(16'h0000, 8'hF0, 0);
        wr(16'h0000, 8'h48, 20);
        settle();
        check("R12 F0 during prog wait", n_prog, exp_prog);

        // R4 and R6 program gap sweep: spacing = 2 + idle
        for (int idle = 6; idle <= 12; idle++) begin
            logic [3:0] sec;
            sec = 4'(idle);
            cmd(8'h60, 2);
            wr({sec, 12'h123}, 8'h68, 0);
            wr(16'h0000, 8'h48, idle);
            settle();
            if (2 + idle >= PROG_GAP) begin
                exp_prog++;
                check("R4 op_sector", {28'b0, op_sector}, {28'b0, sec});
                check("R4 rd_byte", {24'b0, rd_byte}, 32'h01);
            end
            check("R4/R6 prog strobe count", n_prog, exp_prog);
            check("R6 in_read", {31'b0, in_read}, 32'd1);
        end

        // R5 and R6 erase gap sweep
        for (int idle = 14; idle <= 20; idle++) begin
            cmd(8'h80, 2);
            wr(16'h0000, 8'h30, 0);
            wr(16'h0000, 8'h48, idle);
            settle();
            if (2 + idle >= ERASE_GAP) begin
                exp_erase++;
                check("R5 rd_byte", {24'b0, rd_byte}, 32'h00);
            end
            check("R5/R6 erase strobe count", n_erase, exp_erase);
        end

        // R7 status with lock clear, after readback was 01h
        cmd(8'h60, 2); wr(16'h2000, 8'h68, 0); wr(16'h0000, 8'h48, 12);
        settle();
        exp_prog++;
        check("R4 prog before lock", n_prog, exp_prog);
        cmd(8'h50, 2);
        settle();
        check("R7 status unlocked", {24'b0, rd_byte}, 32'h00);

        // R8 lock, then status and blocked verify
        cmd(8'h78, 2); wr(16'h0000, 8'h01, 0);
        cmd(8'h50, 2);
        settle();
        check("R7 status locked", {24'b0, rd_byte}, 32'h02);
        cmd(8'h60, 2); wr(16'h3000, 8'h68, 0); wr(16'h0000, 8'h48, 12);
        settle();
        check("R8 locked prog no strobe", n_prog, exp_prog);
        check("R8 locked prog rd_byte", {24'b0, rd_byte}, 32'h00);
        cmd(8'h80, 2); wr(16'h0000, 8'h30, 0); wr(16'h0000, 8'h48, 20);
        settle();
        check("R8 locked erase no strobe", n_erase, exp_erase);
        check("R8 locked erase rd_byte", {24'b0, rd_byte}, 32'h01);

        // R11 password lock
        cmd(8'h28, 20); wr(16'h0000, 8'h01, 0);
        cmd(8'h38, 20);
        settle();
        check("R11 FF readback", {24'b0, rd_byte}, 32'hFF);
        check("R11 sequence ended", {31'b0, in_read}, 32'd1);
        wr(16'h0000, 8'h99, 0);
        settle();
        check("R11 password unchanged", password, exp_pw);
        check("R9 pw strobe total", n_pw, 1 + 1 + 4 + 6 + 3);

        report();
    end

endmodule